// File: doc/BRIEF.md
# Serial Control Register Slave

This block lets a host read and write a bank of ten 8-bit configuration registers over three wires plus a tri-state return line. The host drops the select line, then sends sixteen serial clock periods. In order, the fields are a 3-bit opcode, a 5-bit register address and 8 data bits, and each field travels least significant bit first. Input bits are taken on rising serial clock edges. During a read the block returns the addressed byte on its data output, one bit per falling edge. A write is committed only when the select line returns high after a complete frame.

All serial inputs are brought into the block's own clock domain by a synchronizer and edge detector. Every register state is therefore clocked by the system clock. The output enable models the tri-state driver: the pad drives only while `sdo_en` is high. One bit of register 6 is not storage. It reflects a read-only status input. Registers 8 and 9 are test locations that read as stored but never accept writes. Addresses from 0x0A upward are ignored.

The select line has no back-pressure and no handshake: the host owns the timing. The serial clock's high and low phases must each last at least SYNC_STAGES+2 system clock cycles.

Top module: `ctl3w_slave`

## Requirements
- R1: After the asynchronous active-low reset the registers hold their defaults: reg0 0x00, reg1 0x15, reg2 0x11, reg3 0x00, reg4 0x00, reg5 0x28, reg6 0x00, reg7 0x28, reg8 0x00, reg9 0x00 (regs_o bits [8*i+7:8*i] hold register i).
- R2: A frame of exactly 16 serial clocks with opcode bits op0,op1,op2 = 1,1,1 writes the data byte to an address 0x00..0x07 when select rises. Bit 0 of each field is sent first: frame bit 0 is op0, bits 3..7 are A0..A4, and bits 8..15 are D0..D7.
- R3: With opcode bits op0,op1,op2 = 1,1,0 and an address 0x00..0x09, sdo_en rises after the falling serial clock edge that follows the eighth rising edge. D0..D7 then appear on sdo, one per falling edge.
- R4: sdo_en is low while select is high, and it is low during the opcode and address phases of every frame.
- R5: Writes to the test addresses 0x08 and 0x09 change nothing. Reads of these addresses return their reset value 0x00.
- R6: Addresses 0x0A to 0x1F change no register on write, and sdo_en stays low on read.
- R7: A frame whose select rises after fewer or more than 16 rising serial clock edges changes no register.
- R8: Any opcode other than the two above changes no register and leaves sdo_en low.
- R9: Bit 3 of register 6 always reads as the stat_i input. A write does not store into that bit, so regs_o shows it as 0.
- R10: A write changes only the addressed register. Without a write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| stat_i | input | 1 | Read-only status bit shown in register 6 bit 3 |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Drive enable for sdo; low means high impedance |
| regs_o | output | NUM_REGS*8 | All register contents, register i at bits [8*i+7:8*i] |

## Verification
Writes and reads to random addresses are mixed with random data and with stray opcodes. This separates the committed write path from the rejected paths: invalid opcode, address above 0x09, and test address. Frames are sometimes cut short or run long, which shows whether the commit truly waits for exactly sixteen clocks. Directed cases toggle the status input between a write and a read of register 6, separating the live status bit from stored data. Every read is compared bit by bit against a bench model, which exposes bit-order and phase errors on the return line.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int OP_W   = 3;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int FRAME_BITS = OP_W + ADDR_W + DATA_W;

  localparam logic [OP_W-1:0] OP_READ  = 3'b011;
  localparam logic [OP_W-1:0] OP_WRITE = 3'b111;

  localparam int STAT_REG = 6;
  localparam int STAT_BIT = 3;
  localparam int FIRST_TEST_REG = 8;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    case (idx)
      1:       return 8'h15;
      2:       return 8'h11;
      5:       return 8'h28;
      7:       return 8'h28;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RST_VAL[b]}};
        prev  <= RST_VAL[b];
      end else begin
        chain <= {chain[STAGES-2:0], d_i[b]};
        prev  <= chain[STAGES-1];
      end
    end
    assign q_o[b]    = chain[STAGES-1];
    assign rise_o[b] = chain[STAGES-1] & ~prev;
    assign fall_o[b] = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/ctl3w_frame.sv
module ctl3w_frame
  import ctl3w_pkg::*;
#(
  parameter int NREG = 10,
  parameter int WR_LIMIT = FIRST_TEST_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              csn_rise,
  input  logic              sck_rise,
  input  logic              sdi_s,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_ok_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IDX_W   = $clog2(FRAME_BITS);
  localparam int HDR     = OP_W + ADDR_W;

  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] sh;
  logic [OP_W-1:0]       op;
  logic [ADDR_W-1:0]     addr;
  logic [DATA_W-1:0]     data;

  assign op   = sh[OP_W-1:0];
  assign addr = sh[HDR-1:OP_W];
  assign data = sh[FRAME_BITS-1:HDR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (csn_s) begin
      cnt <= '0;
    end else if (sck_rise) begin
      if (cnt < CNT_W'(FRAME_BITS)) sh[cnt[IDX_W-1:0]] <= sdi_s;
      if (cnt < CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= csn_rise && (cnt == CNT_W'(FRAME_BITS)) && (op == OP_WRITE)
                  && (addr < ADDR_W'(WR_LIMIT));
      if (csn_rise) begin
        wr_addr_o <= addr;
        wr_data_o <= data;
      end
    end
  end

  assign rd_ok_o = !csn_s && (cnt >= CNT_W'(HDR)) && (cnt <= CNT_W'(FRAME_BITS))
                   && (op == OP_READ) && (addr < ADDR_W'(NREG));
  assign rd_addr_o = addr;

  assert_wr_after_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> csn_s);
  assert_wr_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
  import ctl3w_pkg::*;
#(
  parameter int NREG = 10,
  parameter int WR_LIMIT = FIRST_TEST_REG
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic                   stat_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] DFLT = reg_default(i);
    localparam logic [DATA_W-1:0] KEEP =
      (i == STAT_REG) ? ~(DATA_W'(1) << STAT_BIT) : {DATA_W{1'b1}};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= DFLT;
      else if (wr_stb && wr_addr == ADDR_W'(i)) q[i] <= wr_data & KEEP;
    end
    assign regs_o[i*DATA_W +: DATA_W] = q[i];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data_o = q[i];
    if (rd_addr == ADDR_W'(STAT_REG)) rd_data_o[STAT_BIT] = stat_i;
  end

  assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_o));
  assert_write_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr < ADDR_W'(WR_LIMIT)));
endmodule

// File: rtl/ctl3w_rdout.sv
module ctl3w_rdout
  import ctl3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sck_fall,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  logic [DATA_W-1:0] sh;
  logic              en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      sh <= '0;
    end else if (csn_s || !rd_ok) begin
      en <= 1'b0;
    end else if (sck_fall) begin
      if (!en) begin
        en <= 1'b1;
        sh <= rd_byte;
      end else begin
        sh <= sh >> 1;
      end
    end
  end

  assign sdo_en_o = en;
  assign sdo_o    = en & sh[0];

  assert_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdo_en_o);
  assert_drive_only_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en_o |-> $past(rd_ok));
  assert_bit_held_between_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en_o && $past(sdo_en_o) && !$past(sck_fall)) |-> $stable(sdo_o));
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
  import ctl3w_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  input  logic                       stat_i,
  output logic                       sdo,
  output logic                       sdo_en,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [2:0] s_q, s_rise, s_fall;
  logic              wr_stb, rd_ok;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_byte;

  ctl3w_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sdi, sclk, cs_n}),
    .q_o(s_q), .rise_o(s_rise), .fall_o(s_fall));

  ctl3w_frame #(.NREG(NUM_REGS), .WR_LIMIT(FIRST_TEST_REG)) u_frame (
    .clk(clk), .rst_n(rst_n), .csn_s(s_q[0]), .csn_rise(s_rise[0]),
    .sck_rise(s_rise[1]), .sdi_s(s_q[2]),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_ok_o(rd_ok), .rd_addr_o(rd_addr));

  ctl3w_regfile #(.NREG(NUM_REGS), .WR_LIMIT(FIRST_TEST_REG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stat_i(stat_i),
    .rd_data_o(rd_byte), .regs_o(regs_o));

  ctl3w_rdout u_rdout (
    .clk(clk), .rst_n(rst_n), .csn_s(s_q[0]), .sck_fall(s_fall[1]),
    .rd_ok(rd_ok), .rd_byte(rd_byte), .sdo_o(sdo), .sdo_en_o(sdo_en));
endmodule

// File: tb/ctl3w_slave_tb.sv
module ctl3w_slave_tb;
  localparam int NR = 10;
  localparam int HP = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, stat_i = 1'b0;
  logic sdo, sdo_en;
  logic [NR*8-1:0] regs_o;

  ctl3w_slave u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .stat_i(stat_i), .sdo(sdo), .sdo_en(sdo_en), .regs_o(regs_o));

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] mdl [NR];

  function automatic logic [7:0] dflt(input int a);
    case (a)
      1: return 8'h15;
      2: return 8'h11;
      5: return 8'h28;
      7: return 8'h28;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [4:0] a, input int n);
    if (op != 3'b111 && op != 3'b011) return "R8";
    if (a >= 5'd10) return "R6";
    if (n != 16) return "R7";
    if (a >= 5'd8) return "R5";
    if (op == 3'b111) return (a == 5'd6) ? "R9" : "R2";
    return "R3";
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NR; i++) check({tag, "/R10"}, regs_o[8*i +: 8], mdl[i]);
  endtask

  task automatic xfer(input logic [2:0] op, input logic [4:0] a, input logic [7:0] d,
                      input int nclk, output logic [7:0] rb, output int en_hi,
                      output int en_bad);
    logic [15:0] f;
    f = {d, a, op};
    rb = '0; en_hi = 0; en_bad = 0;
    cs_n = 1'b0;
    tick(HP);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b0;
      sdi = (i < 16) ? f[i] : 1'b0;
      tick(HP);
      if (i >= 8 && i < 16) begin
        rb[i-8] = sdo;
        if (sdo_en) en_hi++;
      end else if (i < 8 && sdo_en) en_bad++;
      sclk = 1'b1;
      tick(HP);
    end
    cs_n = 1'b1;
    tick(2 * HP);
    if (sdo_en) en_bad++;
  endtask

  task automatic run(input logic [2:0] op, input logic [4:0] a, input logic [7:0] d,
                     input int nclk);
    logic [7:0] rb, exp;
    int en_hi, en_bad;
    string tg;
    tg = tag_of(op, a, nclk);
    exp = (a < 5'd10) ? mdl[a] : 8'h00;
    if (a == 5'd6) exp[3] = stat_i;
    xfer(op, a, d, nclk, rb, en_hi, en_bad);
    check({tg, "/R4 stray enable"}, 8'(en_bad), 8'd0);
    if (op == 3'b011 && a < 5'd10 && nclk >= 16) begin
      check({tg, " read data"}, rb, exp);
      check({tg, " enable bits"}, 8'(en_hi), 8'd8);
    end else if (!(op == 3'b011 && a < 5'd10 && nclk > 8)) begin
      check({tg, " no drive"}, 8'(en_hi), 8'd0);
    end
    if (op == 3'b111 && a < 5'd8 && nclk == 16) begin
      mdl[a] = d;
      if (a == 5'd6) mdl[6][3] = 1'b0;
    end
    check_regs(tg);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NR; i++) mdl[i] = dflt(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check_regs("R1 reset");
    check("R1/R4 idle enable", {7'd0, sdo_en}, 8'd0);

    run(3'b011, 5'd5, 8'h00, 16);
    run(3'b111, 5'd3, 8'hA5, 16);
    run(3'b011, 5'd3, 8'h00, 16);
    run(3'b111, 5'd8, 8'hFF, 16);
    run(3'b011, 5'd8, 8'h00, 16);
    run(3'b111, 5'd12, 8'h5A, 16);
    run(3'b011, 5'd12, 8'h00, 16);
    run(3'b111, 5'd2, 8'hC3, 12);
    run(3'b111, 5'd2, 8'hC3, 20);
    run(3'b101, 5'd1, 8'h77, 16);
    run(3'b010, 5'd7, 8'h00, 16);
    stat_i = 1'b1;
    run(3'b111, 5'd6, 8'hFF, 16);
    run(3'b011, 5'd6, 8'h00, 16);
    stat_i = 1'b0;
    run(3'b011, 5'd6, 8'h00, 16);

    for (int t = 0; t < 80; t++) begin
      int r;
      logic [2:0] op;
      logic [4:0] a;
      int n;
      r = $urandom % 8;
      op = (r < 4) ? 3'b111 : (r < 7) ? 3'b011 : 3'($urandom);
      a = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 10);
      n = ($urandom % 8 == 0) ? 9 + int'($urandom % 12) : 16;
      stat_i = 1'($urandom);
      run(op, a, 8'($urandom), n);
    end
    finish_run();
  end
endmodule